// File: doc/BRIEF.md
# Queued Serial Slave with Auto-Advancing Entry Pointer

This block is a serial-peripheral slave that moves data through a small on-chip queue instead of a single shift register. The queue has a transmit table and a receive table. One pointer indexes both tables. While the select line is held low, every time the configured number of bits has arrived the received word is written to the receive table. The pointer then moves on and the next transmit word goes out with no gap. In this way one selection can carry a stream far longer than one word.

The host loads transmit words and reads back received words through a simple register port. That port is a write strobe, an address and write data, with read data returned combinationally. Through the same port the host configures the entry length, the start and end pointers, the wrap behaviour and the interrupt. When the end entry completes, a sticky flag is set and an interrupt can be raised. After that the block either stops accepting bits or wraps back, to address 0 or to the start pointer. If select is released in the middle of an entry, no data is lost: the next selection continues filling the same entry.

Top module: `spi_queue_slave`

## Requirements
- R1: Slave operation needs CTRL[0]=1 and CTRL[1]=0. In any other setting, SCK pulses store nothing, the pointer does not move and `spi_miso_oe` stays low.
- R2: The pointer is loaded from QPTR[3:0] each time slave operation becomes enabled. While selected and enabled, `spi_miso_oe` is high.
- R3: The SPI format is mode 0 with the MSB first. MOSI is sampled on the rising edge of SCK and MISO changes after the falling edge. An entry of n bits sends bits n-1 down to 0 of its transmit word. The received word is stored right-justified, with the bits above n cleared.
- R4: CTRL[11:8] sets the entry length n, where code 0 means 16. After n bits the word is stored at the pointer and the pointer steps by one, modulo 16, while shifting continues.
- R5: If select rises in the middle of an entry, the pointer and the bits received so far are kept, and the next selection completes the same entry.
- R6: When the entry at QPTR[11:8] completes, STAT[0] is set. `irq` equals STAT[0] AND CTRL[4]. Writing 1 to STAT[0] clears it.
- R7: With CTRL[2]=0, completing the end entry sets STAT[1]. From then on, incoming bits are ignored until slave operation is enabled again.
- R8: With CTRL[2]=1, the pointer after the end entry becomes QPTR[3:0] if CTRL[3]=1, or 0 if CTRL[3]=0.
- R9: If the flag is set and the host clears it in the same cycle, the flag stays set.
- R10: The next transmit word is fetched one cycle after an entry completes. Its first bit is on MISO before the first rising edge of SCK for that entry.
- R11: SCK, select and MOSI each pass through two synchroniser flops. An SCK edge takes effect at the third system clock edge after it changes. The system clock must be at least 4 times the SCK rate.
- R12: The host address map is 0x00-0x0F for the transmit table (read/write), 0x10-0x1F for the receive table (read only), 0x20 for CTRL, 0x21 for QPTR and 0x22 for STAT. STAT holds the flag in bit 0, the halt in bit 1 and the pointer in bits [11:8]. Every register and table entry resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 6 | Host register/table address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data (combinational) |
| spi_sck | input | 1 | Serial clock from the master |
| spi_ss_n | input | 1 | Active-low slave select |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | MISO drive enable |
| irq | output | 1 | Queue-end interrupt |

## Verification
The end-of-queue flag can be set by the serial side and cleared by a host write in the same cycle. The bench makes the two coincide using the fixed synchroniser latency. It raises SCK for the last bit of a one-bit end entry and places the write-1-to-clear on exactly the third clock edge after that. It expects the flag to read 0 one edge earlier and to read 1 afterwards. A later write with no competing event must then clear the flag.

// File: rtl/sq_pkg.sv
package sq_pkg;
  typedef enum logic [1:0] {
    RGN_TX   = 2'd0,
    RGN_RX   = 2'd1,
    RGN_CSR  = 2'd2,
    RGN_NONE = 2'd3
  } sq_region_e;

  localparam int CSR_CTRL = 0;
  localparam int CSR_QPTR = 1;
  localparam int CSR_STAT = 2;

  localparam int CTL_EN         = 0;
  localparam int CTL_MASTER     = 1;
  localparam int CTL_WRAP       = 2;
  localparam int CTL_WRAP_START = 3;
  localparam int CTL_IRQ        = 4;
  localparam int CTL_BITS_LSB   = 8;
  localparam int QP_END_LSB     = 8;
  localparam int STAT_DONE      = 0;
  localparam int STAT_HALT      = 1;
  localparam int STAT_PTR_LSB   = 8;
endpackage

// File: rtl/sq_sync.sv
module sq_sync #(
  parameter int           W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_sync,
  output logic [W-1:0] d_prev
);
  logic [W-1:0] st1, st2, st3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st1 <= RST_VAL;
      st2 <= RST_VAL;
      st3 <= RST_VAL;
    end else begin
      st1 <= d_in;
      st2 <= st1;
      st3 <= st2;
    end
  end

  assign d_sync = st2;
  assign d_prev = st3;
endmodule

// File: rtl/sq_host_regs.sv
module sq_host_regs
  import sq_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int DEPTH   = 16,
  parameter int PTR_W   = 4,
  parameter int CODE_W  = 4,
  parameter int HADDR_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_wr,
  input  logic [HADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0]  host_wdata,
  output logic [DATA_W-1:0]  host_rdata,
  input  logic [PTR_W-1:0]   tx_raddr,
  output logic [DATA_W-1:0]  tx_rdata,
  input  logic               rx_we,
  input  logic [PTR_W-1:0]   rx_waddr,
  input  logic [DATA_W-1:0]  rx_wdata,
  input  logic               q_done,
  input  logic               q_halted,
  input  logic [PTR_W-1:0]   q_ptr,
  output logic               cfg_en,
  output logic               cfg_master,
  output logic               cfg_wrap,
  output logic               cfg_wrap_start,
  output logic               cfg_irq_en,
  output logic [CODE_W-1:0]  cfg_bits,
  output logic [PTR_W-1:0]   cfg_start,
  output logic [PTR_W-1:0]   cfg_end,
  output logic               flag_clr
);
  logic [DATA_W-1:0] tx_mem [DEPTH];
  logic [DATA_W-1:0] rx_mem [DEPTH];
  logic [DATA_W-1:0] ctrl_q, qptr_q, stat_w;
  sq_region_e        region;
  logic [PTR_W-1:0]  idx;
  logic              csr_hit_ctrl, csr_hit_qptr, csr_hit_stat;

  assign region = sq_region_e'(host_addr[HADDR_W-1 -: 2]);
  assign idx    = host_addr[PTR_W-1:0];

  assign csr_hit_ctrl = (region == RGN_CSR) && (idx == PTR_W'(CSR_CTRL));
  assign csr_hit_qptr = (region == RGN_CSR) && (idx == PTR_W'(CSR_QPTR));
  assign csr_hit_stat = (region == RGN_CSR) && (idx == PTR_W'(CSR_STAT));

  assign flag_clr = host_wr && csr_hit_stat && host_wdata[STAT_DONE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      qptr_q <= '0;
      for (int i = 0; i < DEPTH; i++) tx_mem[i] <= '0;
    end else if (host_wr) begin
      if (region == RGN_TX) tx_mem[idx] <= host_wdata;
      if (csr_hit_ctrl)     ctrl_q      <= host_wdata;
      if (csr_hit_qptr)     qptr_q      <= host_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) rx_mem[i] <= '0;
    end else if (rx_we) begin
      rx_mem[rx_waddr] <= rx_wdata;
    end
  end

  always_comb begin
    stat_w = '0;
    stat_w[STAT_DONE] = q_done;
    stat_w[STAT_HALT] = q_halted;
    stat_w[STAT_PTR_LSB +: PTR_W] = q_ptr;
  end

  always_comb begin
    host_rdata = '0;
    unique case (region)
      RGN_TX:  host_rdata = tx_mem[idx];
      RGN_RX:  host_rdata = rx_mem[idx];
      RGN_CSR: begin
        if (csr_hit_ctrl) host_rdata = ctrl_q;
        if (csr_hit_qptr) host_rdata = qptr_q;
        if (csr_hit_stat) host_rdata = stat_w;
      end
      default: host_rdata = '0;
    endcase
  end

  assign tx_rdata       = tx_mem[tx_raddr];
  assign cfg_en         = ctrl_q[CTL_EN];
  assign cfg_master     = ctrl_q[CTL_MASTER];
  assign cfg_wrap       = ctrl_q[CTL_WRAP];
  assign cfg_wrap_start = ctrl_q[CTL_WRAP_START];
  assign cfg_irq_en     = ctrl_q[CTL_IRQ];
  assign cfg_bits       = ctrl_q[CTL_BITS_LSB +: CODE_W];
  assign cfg_start      = qptr_q[PTR_W-1:0];
  assign cfg_end        = qptr_q[QP_END_LSB +: PTR_W];
endmodule

// File: rtl/sq_engine.sv
module sq_engine #(
  parameter int DATA_W = 16,
  parameter int PTR_W  = 4,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              sel,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              mosi_bit,
  input  logic [CODE_W-1:0] cfg_bits,
  input  logic [PTR_W-1:0]  cfg_start,
  input  logic [PTR_W-1:0]  cfg_end,
  input  logic              cfg_wrap,
  input  logic              cfg_wrap_start,
  input  logic              flag_clr,
  input  logic [DATA_W-1:0] tx_rdata,
  output logic [PTR_W-1:0]  q_ptr,
  output logic              q_done,
  output logic              q_halted,
  output logic              rx_we,
  output logic [DATA_W-1:0] rx_wdata,
  output logic              miso,
  output logic              ev_bit,
  output logic              ev_entry,
  output logic              ev_qend,
  output logic              ev_prefetch
);
  localparam int LEN_W = CODE_W + 1;

  // Entry length: code 0 selects the full word width.
  function automatic logic [LEN_W-1:0] entry_len(input logic [CODE_W-1:0] code);
    if (code == '0) return LEN_W'(DATA_W);
    return {1'b0, code};
  endfunction

  function automatic logic [DATA_W-1:0] entry_mask(input logic [CODE_W-1:0] code);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < DATA_W; i++)
      if (i < int'(entry_len(code))) m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic [PTR_W-1:0] wrap_dest(input logic to_start,
                                                 input logic [PTR_W-1:0] start);
    return to_start ? start : '0;
  endfunction

  logic              active_q, start_ev, go, pref_q;
  logic [LEN_W-1:0]  cnt, cnt_nx;
  logic              last_bit;
  logic [DATA_W-2:0] rx_sh;
  logic [DATA_W-1:0] rx_full, tx_sh;
  logic [CODE_W-1:0] msb_idx;

  assign start_ev  = active && !active_q;
  assign go        = active && !q_halted && sel;
  assign cnt_nx    = cnt + 1'b1;
  assign last_bit  = (cnt_nx == entry_len(cfg_bits));
  assign rx_full   = {rx_sh, mosi_bit};
  assign msb_idx   = cfg_bits - 1'b1;

  assign ev_bit      = go && sck_rise && !start_ev;
  assign ev_entry    = ev_bit && last_bit;
  assign ev_qend     = ev_entry && (q_ptr == cfg_end);
  assign ev_prefetch = pref_q;

  assign rx_we    = ev_entry;
  assign rx_wdata = rx_full & entry_mask(cfg_bits);
  assign miso     = tx_sh[msb_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      q_ptr    <= '0;
      cnt      <= '0;
      q_halted <= 1'b0;
      pref_q   <= 1'b0;
      rx_sh    <= '0;
    end else begin
      active_q <= active;
      pref_q   <= 1'b0;
      if (start_ev) begin
        q_ptr    <= cfg_start;
        cnt      <= '0;
        q_halted <= 1'b0;
        pref_q   <= 1'b1;
      end else if (ev_bit) begin
        rx_sh <= rx_full[DATA_W-2:0];
        if (last_bit) begin
          cnt    <= '0;
          pref_q <= 1'b1;
          if (ev_qend) begin
            if (cfg_wrap) q_ptr    <= wrap_dest(cfg_wrap_start, cfg_start);
            else          q_halted <= 1'b1;
          end else begin
            q_ptr <= q_ptr + 1'b1;
          end
        end else begin
          cnt <= cnt_nx;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh <= '0;
    end else if (pref_q) begin
      tx_sh <= tx_rdata;
    end else if (go && sck_fall && (cnt != '0)) begin
      tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
    end
  end

  // Set has priority over a simultaneous host clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q_done <= 1'b0;
    else if (ev_qend)  q_done <= 1'b1;
    else if (flag_clr) q_done <= 1'b0;
  end
endmodule

// File: rtl/spi_queue_slave.sv
module spi_queue_slave #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         host_wr,
  input  logic [$clog2(DEPTH)+1:0]     host_addr,
  input  logic [DATA_W-1:0]            host_wdata,
  output logic [DATA_W-1:0]            host_rdata,
  input  logic                         spi_sck,
  input  logic                         spi_ss_n,
  input  logic                         spi_mosi,
  output logic                         spi_miso,
  output logic                         spi_miso_oe,
  output logic                         irq
);
  localparam int PTR_W   = $clog2(DEPTH);
  localparam int CODE_W  = $clog2(DATA_W);
  localparam int HADDR_W = PTR_W + 2;

  logic [2:0]        pin_sync, pin_prev;
  logic              sck_rise, sck_fall, sel_w, mosi_w, active_w;
  logic              cfg_en, cfg_master, cfg_wrap, cfg_wrap_start, cfg_irq_en;
  logic [CODE_W-1:0] cfg_bits;
  logic [PTR_W-1:0]  cfg_start, cfg_end, q_ptr;
  logic              flag_clr, q_done, q_halted, rx_we;
  logic [DATA_W-1:0] rx_wdata, tx_rdata;
  logic              ev_bit, ev_entry, ev_qend, ev_prefetch;

  // bit 2: sck, bit 1: ss_n (idles high), bit 0: mosi
  sq_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_in   ({spi_sck, spi_ss_n, spi_mosi}),
    .d_sync (pin_sync),
    .d_prev (pin_prev)
  );

  assign sck_rise = pin_sync[2] && !pin_prev[2];
  assign sck_fall = !pin_sync[2] && pin_prev[2];
  assign sel_w    = !pin_sync[1];
  assign mosi_w   = pin_sync[0];
  assign active_w = cfg_en && !cfg_master;

  sq_host_regs #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W), .CODE_W(CODE_W), .HADDR_W(HADDR_W)
  ) u_regs (
    .clk            (clk),
    .rst_n          (rst_n),
    .host_wr        (host_wr),
    .host_addr      (host_addr),
    .host_wdata     (host_wdata),
    .host_rdata     (host_rdata),
    .tx_raddr       (q_ptr),
    .tx_rdata       (tx_rdata),
    .rx_we          (rx_we),
    .rx_waddr       (q_ptr),
    .rx_wdata       (rx_wdata),
    .q_done         (q_done),
    .q_halted       (q_halted),
    .q_ptr          (q_ptr),
    .cfg_en         (cfg_en),
    .cfg_master     (cfg_master),
    .cfg_wrap       (cfg_wrap),
    .cfg_wrap_start (cfg_wrap_start),
    .cfg_irq_en     (cfg_irq_en),
    .cfg_bits       (cfg_bits),
    .cfg_start      (cfg_start),
    .cfg_end        (cfg_end),
    .flag_clr       (flag_clr)
  );

  sq_engine #(.DATA_W(DATA_W), .PTR_W(PTR_W), .CODE_W(CODE_W)) u_engine (
    .clk            (clk),
    .rst_n          (rst_n),
    .active         (active_w),
    .sel            (sel_w),
    .sck_rise       (sck_rise),
    .sck_fall       (sck_fall),
    .mosi_bit       (mosi_w),
    .cfg_bits       (cfg_bits),
    .cfg_start      (cfg_start),
    .cfg_end        (cfg_end),
    .cfg_wrap       (cfg_wrap),
    .cfg_wrap_start (cfg_wrap_start),
    .flag_clr       (flag_clr),
    .tx_rdata       (tx_rdata),
    .q_ptr          (q_ptr),
    .q_done         (q_done),
    .q_halted       (q_halted),
    .rx_we          (rx_we),
    .rx_wdata       (rx_wdata),
    .miso           (spi_miso),
    .ev_bit         (ev_bit),
    .ev_entry       (ev_entry),
    .ev_qend        (ev_qend),
    .ev_prefetch    (ev_prefetch)
  );

  assign spi_miso_oe = active_w && sel_w;
  assign irq         = q_done && cfg_irq_en;
endmodule

// File: rtl/sq_checker.sv
module sq_checker #(
  parameter int PTR_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             active,
  input logic             ev_bit,
  input logic             ev_entry,
  input logic             ev_qend,
  input logic             ev_prefetch,
  input logic [PTR_W-1:0] q_ptr,
  input logic             q_done,
  input logic             q_halted,
  input logic             rx_we
);
  AST_IDLE_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !ev_bit); // R1

  AST_PTR_HOLD_MIDWORD: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_bit && !ev_entry) |=> $stable(q_ptr)); // R4

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_entry && !ev_qend) |=> (q_ptr == PTR_W'($past(q_ptr) + 1'b1))); // R4

  AST_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_qend |=> q_done); // R9

  AST_HALT_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    q_halted |-> !rx_we); // R7

  AST_PREFETCH_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_entry |=> ev_prefetch); // R10
endmodule

bind spi_queue_slave sq_checker #(.PTR_W(PTR_W)) u_sq_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .active      (active_w),
  .ev_bit      (ev_bit),
  .ev_entry    (ev_entry),
  .ev_qend     (ev_qend),
  .ev_prefetch (ev_prefetch),
  .q_ptr       (q_ptr),
  .q_done      (q_done),
  .q_halted    (q_halted),
  .rx_we       (rx_we)
);

// File: tb/spi_queue_slave_bench.sv
module spi_queue_slave_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [5:0]  host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        spi_sck = 1'b0, spi_ss_n = 1'b1, spi_mosi = 1'b0;
  logic        spi_miso, spi_miso_oe, irq;

  int n_run = 0, n_fail = 0;
  bit finished = 0;
  bit exp_q[$];
  bit chk_q[$];

  always #2 clk = ~clk;

  spi_queue_slave u_spi_queue_slave (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .spi_sck(spi_sck),
    .spi_ss_n(spi_ss_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .spi_miso_oe(spi_miso_oe), .irq(irq)
  );

  function automatic logic [15:0] tx_val(int i);
    return 16'h5A00 ^ 16'(i * 16'h1357);
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  // Monitor: MISO must match the scoreboard at each SCK rising edge (R3, R10)
  always @(posedge spi_sck) begin
    if (exp_q.size() > 0) begin
      bit e, c;
      e = exp_q.pop_front();
      c = chk_q.pop_front();
      if (c) begin
        n_run++;
        if (spi_miso !== e) begin
          n_fail++;
          $display("FAIL R3/R10 miso actual=%b expected=%b", spi_miso, e);
        end
      end
    end
  end

  task automatic clk_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [5:0] a, logic [15:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [15:0] d);
    @(negedge clk);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  task automatic rd_chk(string req, logic [5:0] a, logic [15:0] exp);
    logic [15:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic sbit(bit b, bit exp_b, bit chk);
    @(negedge clk);
    spi_mosi = b;
    exp_q.push_back(exp_b);
    chk_q.push_back(chk);
    clk_n(4);
    spi_sck = 1'b1;
    clk_n(4);
    spi_sck = 1'b0;
    clk_n(4);
  endtask

  task automatic sword(logic [15:0] d, int n, logic [15:0] t, bit chk);
    for (int i = n - 1; i >= 0; i--) sbit(d[i], t[i], chk);
  endtask

  task automatic sel();
    @(negedge clk); spi_ss_n = 1'b0; clk_n(6);
  endtask

  task automatic desel();
    @(negedge clk); spi_ss_n = 1'b1; clk_n(6);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL R11 watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    clk_n(5);
    rst_n = 1'b1;
    clk_n(2);

    // Reset state
    rd_chk("R12 stat reset", 6'h22, 16'h0000);
    rd_chk("R12 ctrl reset", 6'h20, 16'h0000);
    check("R12 oe reset", {15'd0, spi_miso_oe}, 16'h0000);
    check("R6 irq reset", {15'd0, irq}, 16'h0000);

    for (int i = 0; i < 16; i++) wr(6'(i), tx_val(i));
    rd_chk("R12 tx readback", 6'h03, tx_val(3));

    // A: 8-bit entries, start 2, end 4, no wrap, irq enabled
    wr(6'h21, 16'h0402);
    wr(6'h20, 16'h0811);
    clk_n(4);
    sel();
    check("R2 oe when selected", {15'd0, spi_miso_oe}, 16'h0001);
    sword(16'h003C, 8, tx_val(2), 1);
    sword(16'h00C3, 8, tx_val(3), 1);
    sword(16'h0096, 8, tx_val(4), 1);
    rd_chk("R6 R7 stat after end", 6'h22, 16'h0403);
    check("R6 irq raised", {15'd0, irq}, 16'h0001);
    sword(16'h00FF, 8, 16'h0000, 0);
    rd_chk("R4 rx entry2", 6'h12, 16'h003C);
    rd_chk("R4 rx entry3", 6'h13, 16'h00C3);
    rd_chk("R3 rx entry4", 6'h14, 16'h0096);
    rd_chk("R7 ignored bits", 6'h15, 16'h0000);
    rd_chk("R7 stat unchanged", 6'h22, 16'h0403);
    desel();
    wr(6'h22, 16'h0001);
    rd_chk("R6 w1c clears", 6'h22, 16'h0402);
    check("R6 irq cleared", {15'd0, irq}, 16'h0000);

    // B: 16-bit entries, start 14, end 15, wrap to start, partial resume
    wr(6'h20, 16'h0000);
    wr(6'h21, 16'h0F0E);
    wr(6'h20, 16'h000D);
    clk_n(4);
    sel();
    for (int i = 15; i >= 6; i--) sbit(1'((16'hBEEF >> i) & 1), tx_val(14)[i], 1);
    desel();
    rd_chk("R5 ptr held", 6'h22, 16'h0E00);
    rd_chk("R5 entry not stored", 6'h1E, 16'h0000);
    sel();
    for (int i = 5; i >= 0; i--) sbit(1'((16'hBEEF >> i) & 1), tx_val(14)[i], 1);
    rd_chk("R5 resumed word", 6'h1E, 16'hBEEF);
    sword(16'h1234, 16, tx_val(15), 1);
    rd_chk("R8 wrap to start", 6'h22, 16'h0E01);
    check("R6 irq masked", {15'd0, irq}, 16'h0000);
    sword(16'h5678, 16, tx_val(14), 1);
    rd_chk("R8 overwrite after wrap", 6'h1E, 16'h5678);
    rd_chk("R4 rx entry15", 6'h1F, 16'h1234);
    rd_chk("R4 ptr after wrap", 6'h22, 16'h0F01);
    desel();
    wr(6'h22, 16'h0001);

    // C: 4-bit entries, start=end=5, wrap to address 0, masking
    wr(6'h20, 16'h0000);
    wr(6'h21, 16'h0505);
    wr(6'h20, 16'h0405);
    clk_n(4);
    sel();
    sword(16'h000A, 4, tx_val(5), 1);
    sword(16'h0007, 4, tx_val(0), 1);
    rd_chk("R8 wrap to zero", 6'h22, 16'h0101);
    rd_chk("R4 rx entry5", 6'h15, 16'h000A);
    rd_chk("R3 upper bits cleared", 6'h10, 16'h0007);
    desel();
    wr(6'h22, 16'h0001);

    // D: master bit set, slave inactive
    wr(6'h20, 16'h0403);
    clk_n(4);
    sel();
    check("R1 oe low in master", {15'd0, spi_miso_oe}, 16'h0000);
    sword(16'h000F, 4, 16'h0000, 0);
    rd_chk("R1 nothing stored", 6'h11, 16'h0000);
    rd_chk("R1 ptr unchanged", 6'h22, 16'h0100);
    desel();

    // E: flag set and host clear in the same cycle
    wr(6'h20, 16'h0000);
    wr(6'h21, 16'h0707);
    wr(6'h20, 16'h0105);
    clk_n(4);
    sel();
    @(negedge clk);
    spi_mosi = 1'b1;
    spi_sck  = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    host_wr = 1'b1; host_addr = 6'h22; host_wdata = 16'h0001;
    #1 d = host_rdata;
    check("R11 not set before third edge", d & 16'h0001, 16'h0000);
    @(posedge clk);
    @(negedge clk);
    host_wr = 1'b0;
    #1 d = host_rdata;
    check("R9 set beats clear", d, 16'h0001);
    clk_n(2);
    spi_sck = 1'b0;
    clk_n(4);
    rd_chk("R4 one-bit entry", 6'h17, 16'h0001);
    wr(6'h22, 16'h0001);
    rd_chk("R6 later clear", 6'h22, 16'h0000);
    desel();

    check("R3 scoreboard drained", 16'(exp_q.size()), 16'h0000);
    finished = 1;
    summary();
    $finish;
  end
endmodule